// File: doc/BRIEF.md
# PLL Setting Search Engine

The engine is a sequential search unit for configuring a PLL-style clock synthesizer. It is given a wanted output frequency and the frequency of the reference clock, both in kHz, and a start strobe. It then looks for the reference divider, feedback multiplier and output divider whose product comes closest to the wanted frequency, while keeping the VCO inside its legal band. When the search ends it reports the three settings and the frequency they actually give, and it marks the result with a one-cycle done pulse.

The search visits reference dividers in ascending order. For each one it walks the feedback multipliers that keep the VCO inside its band, also in ascending order. For each multiplier it predicts the best output divider by rounded fixed-point arithmetic. An exact hit ends the search at once. All quotients come from a single shared restoring divider that yields one quotient bit per clock, so a search takes a few hundred to some tens of thousands of cycles, depending on the reference. The reference must not exceed 4,000,000 kHz.

Top module: `clk_cfg_search`

## Requirements
- R1: The wanted frequency is limited to the range 4,000..800,000 kHz before any candidate is evaluated. The result is the same as for the nearest end of that range.
- R2: The reference divider D starts at 2 when the reference exceeds 450,000 kHz, and at 1 otherwise. It rises to at most min(reference / 10,000, 106).
- R3: For each D, the feedback multipliers M go in ascending order from max(2, D·ceil(600,000/ref)) up to min(64, D·floor(1,200,000/ref)). A D whose range is empty is skipped.
- R4: For each D, a per-mille factor is computed as k = (ref·1000 + (D·f)/2) / (D·f). The output divider is C = (k·M + 500) / 1000, limited to 1..128.
- R5: The achieved frequency is ((ref·M)/D)/C, with every division truncating. Its error is the absolute difference from the limited wanted frequency.
- R6: A candidate replaces the held best only when its error is strictly smaller. The held error starts at 800,000, so the earliest of equal candidates is kept.
- R7: A candidate with zero error ends the search at once. When the first candidate is exact, done follows start within 400 cycles.
- R8: A zero reference, or a search in which no candidate improves on the starting error, reports 0 on all four result outputs.
- R9: busy is high from the cycle after an accepted start until done. done is high for exactly one cycle. The four result outputs change only in the cycle in which done is high.
- R10: A start that arrives while busy is high is ignored. The running search finishes with the result for its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search with the present inputs |
| target_khz | input | 32 | Wanted output frequency, kHz |
| ref_khz | input | 32 | Reference clock frequency, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| main_div | output | 7 | Chosen reference divider D |
| fb_mult | output | 7 | Chosen feedback multiplier M |
| out_div | output | 8 | Chosen output divider C |
| freq_khz | output | 32 | Achieved output frequency, kHz (0 means no result) |

## Verification
A wrong loop bound or a wrong visiting order changes which setting wins. This shows at done as a different D, M or C, or as a larger achieved frequency error, even when the frequency is still close. A stale best record, or a broken tie rule, gives a mismatch on the very first search it affects. A missing early exit shows as the latency of an exact-hit search growing far past the few hundred cycles one candidate needs. Any state corruption during a search reaches the ports only at done, so each search is compared in full at its done pulse.

// File: rtl/clksrch_pkg.sv
package clksrch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DMAX,
        ST_LO,
        ST_HI,
        ST_DSET,
        ST_MUL,
        ST_C,
        ST_F1,
        ST_F2,
        ST_DONE
    } srch_st_e;

    function automatic logic [31:0] absdiff32(input logic [31:0] a, input logic [31:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/clksrch_div.sv
module clksrch_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  q;
        logic [W-1:0]  den;
        logic [W-1:0]  num;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } div_s;

    div_s s_d, s_q;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        shifted  = {s_q.rem, s_q.q[W-1]};
        trial    = shifted - {1'b0, s_q.den};
        if (start && !s_q.busy) begin
            s_d.rem  = '0;
            s_d.q    = num;
            s_d.num  = num;
            s_d.den  = den;
            s_d.cnt  = CW'(W);
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            if (!trial[W]) begin
                s_d.rem = trial[W-1:0];
                s_d.q   = {s_q.q[W-2:0], 1'b1};
            end else begin
                s_d.rem = shifted[W-1:0];
                s_d.q   = {s_q.q[W-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign quot = s_q.q;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (({{W{1'b0}}, s_q.q} * {{W{1'b0}}, s_q.den} + {{W{1'b0}}, s_q.rem})
                      == {{W{1'b0}}, s_q.num}) && (s_q.rem < s_q.den)); // R5

endmodule

// File: rtl/clksrch_best.sv
module clksrch_best #(
    parameter int DW       = 32,
    parameter int DIV_W    = 7,
    parameter int MUL_W    = 7,
    parameter int ODIV_W   = 8,
    parameter int ERR_INIT = 800000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cand_vld,
    input  logic [DW-1:0]     cand_err,
    input  logic [DIV_W-1:0]  cand_d,
    input  logic [MUL_W-1:0]  cand_m,
    input  logic [ODIV_W-1:0] cand_c,
    input  logic [DW-1:0]     cand_f,
    output logic [DIV_W-1:0]  best_d,
    output logic [MUL_W-1:0]  best_m,
    output logic [ODIV_W-1:0] best_c,
    output logic [DW-1:0]     best_f
);
    typedef struct packed {
        logic [DW-1:0]     err;
        logic [DIV_W-1:0]  d;
        logic [MUL_W-1:0]  m;
        logic [ODIV_W-1:0] c;
        logic [DW-1:0]     f;
    } best_s;

    best_s b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clear) begin
            b_d     = '0;
            b_d.err = DW'(ERR_INIT);
        end else if (cand_vld && (cand_err < b_q.err)) begin
            b_d.err = cand_err;
            b_d.d   = cand_d;
            b_d.m   = cand_m;
            b_d.c   = cand_c;
            b_d.f   = cand_f;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q     <= '0;
            b_q.err <= DW'(ERR_INIT);
        end else begin
            b_q <= b_d;
        end
    end

    assign best_d = b_q.d;
    assign best_m = b_q.m;
    assign best_c = b_q.c;
    assign best_f = b_q.f;

    AST_BEST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> (b_q.err <= $past(b_q.err))); // R6

    AST_TIE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && cand_vld && cand_err == b_q.err) |=> $stable(b_q.f) && $stable(b_q.m)); // R6

endmodule

// File: rtl/clk_cfg_search.sv
module clk_cfg_search #(
    parameter int DW         = 32,
    parameter int FOUT_MIN   = 4000,
    parameter int FOUT_MAX   = 800000,
    parameter int REF_HI     = 450000,
    parameter int PFD_MIN    = 10000,
    parameter int DIV_MAX    = 106,
    parameter int VCO_MIN    = 600000,
    parameter int VCO_MAX    = 1200000,
    parameter int FB_MIN     = 2,
    parameter int FB_MAX     = 64,
    parameter int ODIV_MIN   = 1,
    parameter int ODIV_MAX   = 128,
    parameter int PERMILLE   = 1000,
    localparam int DIV_W     = $clog2(DIV_MAX + 2),
    localparam int MUL_W     = $clog2(FB_MAX + 2),
    localparam int ODIV_W    = $clog2(ODIV_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     target_khz,
    input  logic [DW-1:0]     ref_khz,
    output logic              busy,
    output logic              done,
    output logic [DIV_W-1:0]  main_div,
    output logic [MUL_W-1:0]  fb_mult,
    output logic [ODIV_W-1:0] out_div,
    output logic [DW-1:0]     freq_khz
);
    import clksrch_pkg::*;

    typedef struct packed {
        srch_st_e          st;
        logic              issued;
        logic [DW-1:0]     tgt;
        logic [DW-1:0]     refv;
        logic [DW-1:0]     dmax;
        logic [DW-1:0]     lo;
        logic [DW-1:0]     hi;
        logic [DIV_W-1:0]  d;
        logic [MUL_W-1:0]  m;
        logic [MUL_W-1:0]  mmax;
        logic [DW-1:0]     mult;
        logic [ODIV_W-1:0] c;
        logic [DW-1:0]     f1;
        logic              busy;
        logic              done;
        logic [DIV_W-1:0]  o_d;
        logic [MUL_W-1:0]  o_m;
        logic [ODIV_W-1:0] o_c;
        logic [DW-1:0]     o_f;
    } ctl_s;

    ctl_s s_d, s_q;

    logic              div_start, div_busy, div_done;
    logic [DW-1:0]     div_num, div_den, div_quot;
    logic              bst_clear, cand_vld;
    logic [DW-1:0]     cand_err;
    logic [DIV_W-1:0]  best_d;
    logic [MUL_W-1:0]  best_m;
    logic [ODIV_W-1:0] best_c;
    logic [DW-1:0]     best_f;

    logic [DW-1:0] d_ext, m_ext, dv, rng_lo, rng_hi, c_raw, tgt_in;

    clksrch_div #(.W(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    clksrch_best #(
        .DW      (DW),
        .DIV_W   (DIV_W),
        .MUL_W   (MUL_W),
        .ODIV_W  (ODIV_W),
        .ERR_INIT(FOUT_MAX)
    ) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (bst_clear),
        .cand_vld (cand_vld),
        .cand_err (cand_err),
        .cand_d   (s_q.d),
        .cand_m   (s_q.m),
        .cand_c   (s_q.c),
        .cand_f   (div_quot),
        .best_d   (best_d),
        .best_m   (best_m),
        .best_c   (best_c),
        .best_f   (best_f)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        div_start = 1'b0;
        div_num   = '0;
        div_den   = DW'(1);
        bst_clear = 1'b0;
        cand_vld  = 1'b0;
        d_ext     = DW'(s_q.d);
        m_ext     = DW'(s_q.m);
        dv        = d_ext * s_q.tgt;
        rng_lo    = d_ext * s_q.lo;
        rng_hi    = d_ext * s_q.hi;
        c_raw     = div_quot;
        cand_err  = absdiff32(div_quot, s_q.tgt);
        tgt_in    = target_khz;
        if (tgt_in < DW'(FOUT_MIN)) tgt_in = DW'(FOUT_MIN);
        if (tgt_in > DW'(FOUT_MAX)) tgt_in = DW'(FOUT_MAX);
        if (rng_lo < DW'(FB_MIN)) rng_lo = DW'(FB_MIN);
        if (rng_hi > DW'(FB_MAX)) rng_hi = DW'(FB_MAX);
        if (c_raw > DW'(ODIV_MAX)) c_raw = DW'(ODIV_MAX);
        if (c_raw < DW'(ODIV_MIN)) c_raw = DW'(ODIV_MIN);

        // operands of the shared divider, chosen by the stage
        case (s_q.st)
            ST_DMAX: begin div_num = s_q.refv;                          div_den = DW'(PFD_MIN);  end
            ST_LO:   begin div_num = DW'(VCO_MIN) + s_q.refv - 1'b1;    div_den = s_q.refv;      end
            ST_HI:   begin div_num = DW'(VCO_MAX);                      div_den = s_q.refv;      end
            ST_MUL:  begin div_num = s_q.refv * DW'(PERMILLE) + (dv >> 1); div_den = dv;         end
            ST_C:    begin div_num = s_q.mult * m_ext + DW'(PERMILLE / 2); div_den = DW'(PERMILLE); end
            ST_F1:   begin div_num = s_q.refv * m_ext;                  div_den = d_ext;         end
            ST_F2:   begin div_num = s_q.f1;                            div_den = DW'(s_q.c);    end
            default: ;
        endcase

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.tgt    = tgt_in;
                    s_d.refv   = ref_khz;
                    s_d.busy   = 1'b1;
                    s_d.issued = 1'b0;
                    bst_clear  = 1'b1;
                    s_d.st     = (ref_khz == '0) ? ST_DONE : ST_DMAX;
                end
            end
            ST_DSET: begin
                if (d_ext > s_q.dmax) begin
                    s_d.st = ST_DONE;
                end else if (rng_lo > rng_hi) begin
                    s_d.d = s_q.d + 1'b1;
                end else begin
                    s_d.m    = rng_lo[MUL_W-1:0];
                    s_d.mmax = rng_hi[MUL_W-1:0];
                    s_d.st   = ST_MUL;
                end
            end
            ST_DONE: begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.o_d  = best_d;
                s_d.o_m  = best_m;
                s_d.o_c  = best_c;
                s_d.o_f  = best_f;
                s_d.st   = ST_IDLE;
            end
            default: begin
                if (!s_q.issued) begin
                    div_start  = 1'b1;
                    s_d.issued = 1'b1;
                end else if (div_done) begin
                    s_d.issued = 1'b0;
                    case (s_q.st)
                        ST_DMAX: begin
                            s_d.dmax = (div_quot > DW'(DIV_MAX)) ? DW'(DIV_MAX) : div_quot;
                            s_d.st   = ST_LO;
                        end
                        ST_LO: begin
                            s_d.lo = div_quot;
                            s_d.st = ST_HI;
                        end
                        ST_HI: begin
                            s_d.hi = div_quot;
                            s_d.d  = (s_q.refv > DW'(REF_HI)) ? DIV_W'(2) : DIV_W'(1);
                            s_d.st = ST_DSET;
                        end
                        ST_MUL: begin
                            s_d.mult = div_quot;
                            s_d.st   = ST_C;
                        end
                        ST_C: begin
                            s_d.c  = c_raw[ODIV_W-1:0];
                            s_d.st = ST_F1;
                        end
                        ST_F1: begin
                            s_d.f1 = div_quot;
                            s_d.st = ST_F2;
                        end
                        ST_F2: begin
                            cand_vld = 1'b1;
                            if (cand_err == '0) begin
                                s_d.st = ST_DONE;
                            end else if (s_q.m < s_q.mmax) begin
                                s_d.m  = s_q.m + 1'b1;
                                s_d.st = ST_C;
                            end else begin
                                s_d.d  = s_q.d + 1'b1;
                                s_d.st = ST_DSET;
                            end
                        end
                        default: s_d.st = ST_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign main_div = s_q.o_d;
    assign fb_mult  = s_q.o_m;
    assign out_div  = s_q.o_c;
    assign freq_khz = s_q.o_f;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(freq_khz) && $stable(fb_mult) && $stable(out_div) && $stable(main_div)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(s_q.tgt) && $stable(s_q.refv)); // R10

    AST_FB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && freq_khz != '0) |-> (fb_mult >= MUL_W'(FB_MIN)) && (fb_mult <= MUL_W'(FB_MAX))); // R3

    AST_ODIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && freq_khz != '0) |-> (out_div >= ODIV_W'(ODIV_MIN)) && (out_div <= ODIV_W'(ODIV_MAX))); // R4

    AST_MAINDIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && freq_khz != '0) |-> (main_div >= DIV_W'(1)) && (main_div <= DIV_W'(DIV_MAX))); // R2

    AST_DIV_ONE_USER: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> !div_busy); // R5

endmodule

// File: tb/sim_clk_cfg_search.sv
`timescale 1ns/1ps
module sim_clk_cfg_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_khz = '0;
    logic [31:0] ref_khz = '0;
    logic        busy, done;
    logic [6:0]  main_div, fb_mult;
    logic [7:0]  out_div;
    logic [31:0] freq_khz;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_cfg_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .target_khz(target_khz), .ref_khz(ref_khz),
        .busy(busy), .done(done),
        .main_div(main_div), .fb_mult(fb_mult), .out_div(out_div), .freq_khz(freq_khz)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected result computed from the requirement text
    function automatic void model(input longint tgt_in, input longint rf,
                                  output longint od, output longint om,
                                  output longint oc, output longint of);
        longint t, d0, dmax, lo, hi, best, mn, mx, k, c, f, e;
        bit hit;
        od = 0; om = 0; oc = 0; of = 0;
        if (rf == 0) return;
        t = tgt_in;
        if (t < 4000) t = 4000;                        // R1
        if (t > 800000) t = 800000;
        d0 = (rf > 450000) ? 2 : 1;                    // R2
        dmax = rf / 10000;
        if (dmax > 106) dmax = 106;
        lo = (600000 + rf - 1) / rf;                   // R3
        hi = 1200000 / rf;
        best = 800000;                                 // R6
        hit = 0;
        for (longint d = d0; d <= dmax && !hit; d++) begin
            mn = d * lo; mx = d * hi;
            if (mn < 2) mn = 2;
            if (mx > 64) mx = 64;
            k = (rf * 1000 + (d * t) / 2) / (d * t);   // R4
            for (longint m = mn; m <= mx && !hit; m++) begin
                c = (k * m + 500) / 1000;
                if (c > 128) c = 128;
                if (c < 1) c = 1;
                f = ((rf * m) / d) / c;                // R5
                e = (f >= t) ? f - t : t - f;
                if (e < best) begin
                    best = e; od = d; om = m; oc = c; of = f;
                end
                if (e == 0) hit = 1;                   // R7
            end
        end
    endfunction

    task automatic run_search(input longint tgt, input longint rf, input string req,
                              input int max_lat, input bit poke_busy);
        longint ed, em, ec, ef;
        int t0;
        bit got;
        model(tgt, rf, ed, em, ec, ef);
        @(negedge clk);
        target_khz = tgt[31:0];
        ref_khz    = rf[31:0];
        start      = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 || done == 1'b1, "R9 busy after start", longint'(busy), 1);
        got = 0;
        for (int i = 0; i < 60000 && !got; i++) begin
            if (poke_busy && i == 20) begin
                // R10: a second start with other inputs during the search
                target_khz = 32'd123457;
                ref_khz    = 32'd333333;
                start      = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) got = 1;
            else @(negedge clk);
        end
        start = 1'b0;
        check(got, {req, " done seen"}, longint'(got), 1);
        if (!got) return;
        check(freq_khz == ef[31:0], {req, " freq"}, longint'(freq_khz), ef);
        check(main_div == ed[6:0], {req, " main_div"}, longint'(main_div), ed);
        check(fb_mult == em[6:0], {req, " fb_mult"}, longint'(fb_mult), em);
        check(out_div == ec[7:0], {req, " out_div"}, longint'(out_div), ec);
        if (max_lat > 0)
            check(cyc - t0 <= max_lat, "R7 early exit latency", longint'(cyc - t0), longint'(max_lat));
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", longint'(done), 0);
        check(busy == 1'b0, "R9 busy cleared", longint'(busy), 0);
        repeat (5) @(negedge clk);
        check(freq_khz == ef[31:0] && done == 1'b0, "R9 outputs hold", longint'(freq_khz), ef);
    endtask

    initial begin
        int unsigned r1, r2;
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        check(busy == 0 && done == 0 && freq_khz == 0 && fb_mult == 0, "R9 reset state",
              longint'(freq_khz), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_search(50000, 100000, "R7 exact first", 400, 0);
        run_search(1, 500000, "R1 low clamp", 0, 0);
        run_search(2000000, 700000, "R1 high clamp", 0, 0);
        run_search(100000, 460000, "R2 start at 2", 0, 0);
        run_search(148500, 450000, "R2 start at 1", 0, 0);
        run_search(74250, 100000, "R3 wide range", 0, 0);
        run_search(100000, 0, "R8 zero ref", 0, 0);
        run_search(100000, 5000, "R8 no divider", 0, 0);
        run_search(65000, 800000, "R10 busy start", 0, 1);
        for (int n = 0; n < 7; n++) begin
            r1 = 400001 + ($urandom % 600000);
            r2 = 1000 + ($urandom % 900000);
            run_search(longint'(r2), longint'(r1), "R4 R5 R6 random", 0, 0);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule